// File: doc/BRIEF.md
# Configurable GPIO Port Register

This block is one 8-bit general-purpose I/O port as seen from a simple processor bus. Software writes an output latch as a whole byte or one bit at a time. It sets each pin to push-pull or open-drain drive, and to digital or analog input. A configuration register holds a global weak pull-up disable and a crossbar enable. When the crossbar enable is set, a peripheral can take over any pin it owns, and the pin then drives the peripheral's value instead of the latch bit.

The pad is modelled as three per-pin outputs: a drive enable, a drive value and a weak pull-up request. A pin-level input comes back through a two-flop synchronizer. A read of the port register returns one of two values, chosen by a qualifier on the access. An ordinary read returns the synchronized pin levels, and pins in analog mode read as zero. A read marked read-modify-write returns the latch, so that the processor's AND/OR/XOR, bit-set and increment style instructions change the latch rather than copy the pins into it. Read data is combinational from the registered state, so it is valid in the same cycle as the request.

Top module: `gpioPort`

## Requirements
- R1: After reset the latch is 0xFF, every pin is open-drain (mode register 0x00) and digital (input-mode register 0xFF), and the configuration register reads 0x00. Bit 0 of the configuration register is the pull-up disable and bit 1 is the crossbar enable, so at reset pull-ups are enabled and the crossbar is off.
- R2: The register addresses are 0 port latch, 1 output mode, 2 input mode and 3 configuration. A byte write stores busWdata, and that value is visible from the next cycle onward.
- R3: A write with busBitMode set changes only the bit selected by busBitIdx, loading busWdata bit 0 into it. All other bits of that register are left unchanged.
- R4: An ordinary read of address 0 returns the pin levels through a two-stage synchronizer. A change on pinIn is visible on the first read that follows the second rising edge after the change, and is not visible after only one edge.
- R5: On an ordinary read of address 0, any pin whose input-mode bit is 0 (analog) reads as 0.
- R6: A read of address 0 with busRmw set returns the latch, whatever the pin levels are.
- R7: A digital pin whose output-mode bit is 1 (push-pull) has padOe=1 and padOut equal to its output value.
- R8: A digital pin whose output-mode bit is 0 (open-drain) has padOe=1 and padOut=0 when its output value is 0, and padOe=0 when its output value is 1.
- R9: An analog pin never has padOe or padPullUp asserted.
- R10: padPullUp is 1 for a pin that is digital, not driven low, and has the global pull-up disable clear. It is 0 otherwise.
- R11: When the crossbar enable is 1 and periphOwn[i] is 1, the output value of pin i is periphOut[i]; otherwise it is latch bit i. An ordinary read still returns the pin level of an owned pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 write, 0 read |
| busRmw | input | 1 | Read belongs to a read-modify-write access |
| busBitMode | input | 1 | Write targets one bit only |
| busBitIdx | input | 3 | Bit selected in bit mode |
| busAddr | input | 2 | Register select |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the request cycle |
| pinIn | input | 8 | Pin levels seen at the pads |
| periphOwn | input | 8 | Per-pin peripheral ownership |
| periphOut | input | 8 | Peripheral output values |
| padOe | output | 8 | Pad drive enable |
| padOut | output | 8 | Pad drive value |
| padPullUp | output | 8 | Weak pull-up request |

## Verification
Register writes take effect at the rising edge on which they are presented. The bench therefore drives each access at a falling edge and looks at registers and pad outputs at the next falling edge. Read data is combinational, so it is sampled 1 ns after the read is driven, within the same cycle. Pin changes need two rising edges before reads show them. The synchronizer test reads once after one edge, where the old level is expected, and again after the second edge, where the new level is expected. Pad outputs follow register contents and peripheral inputs with no added delay, and they are checked one falling edge after the write that set them.

// File: rtl/gpioPortPkg.sv
package gpioPortPkg;

  typedef enum logic [1:0] {
    REG_PORT  = 2'd0,
    REG_OMODE = 2'd1,
    REG_IMODE = 2'd2,
    REG_CFG   = 2'd3
  } regSel_e;

  localparam int CFG_PULLDIS_BIT = 0;
  localparam int CFG_XBAR_BIT    = 1;

  typedef struct packed {
    logic    wrPort;
    logic    wrOutMode;
    logic    wrInMode;
    logic    wrCfg;
    logic    bitMode;
    logic    rdEn;
    logic    rdRmw;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/gpioPortCtrl.sv
module gpioPortCtrl
  import gpioPortPkg::*;
(
  input  logic         busSel,
  input  logic         busWrite,
  input  logic         busRmw,
  input  logic         busBitMode,
  input  logic [1:0]   busAddr,
  output ctrlStrobes_t strobes
);

  regSel_e sel;
  logic    wrAny;

  assign sel   = regSel_e'(busAddr);
  assign wrAny = busSel & busWrite;

  always_comb begin
    strobes           = '0;
    strobes.wrPort    = wrAny & (sel == REG_PORT);
    strobes.wrOutMode = wrAny & (sel == REG_OMODE);
    strobes.wrInMode  = wrAny & (sel == REG_IMODE);
    strobes.wrCfg     = wrAny & (sel == REG_CFG);
    strobes.bitMode   = wrAny & busBitMode;
    strobes.rdEn      = busSel & ~busWrite;
    strobes.rdRmw     = busSel & ~busWrite & busRmw;
    strobes.rdSel     = sel;
  end

endmodule

// File: rtl/gpioPortDatapath.sv
module gpioPortDatapath
  import gpioPortPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [IDX_W-1:0] busBitIdx,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] periphOwn,
  input  logic [WIDTH-1:0] periphOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp
);

  logic [WIDTH-1:0] portLatch, outModeQ, inModeQ;
  logic             pullDisQ, xbarEnQ;
  logic [WIDTH-1:0] wrMask, wrVal;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync, outVal;

  // Write mask and value: whole byte, or one bit taken from wdata[0]
  always_comb begin
    if (strobes.bitMode) begin
      wrMask            = '0;
      wrMask[busBitIdx] = 1'b1;
      wrVal             = {WIDTH{busWdata[0]}};
    end else begin
      wrMask = '1;
      wrVal  = busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portLatch <= '1;
      outModeQ  <= '0;
      inModeQ   <= '1;
      pullDisQ  <= 1'b0;
      xbarEnQ   <= 1'b0;
    end else begin
      if (strobes.wrPort)    portLatch <= (portLatch & ~wrMask) | (wrVal & wrMask);
      if (strobes.wrOutMode) outModeQ  <= (outModeQ  & ~wrMask) | (wrVal & wrMask);
      if (strobes.wrInMode)  inModeQ   <= (inModeQ   & ~wrMask) | (wrVal & wrMask);
      if (strobes.wrCfg) begin
        if (wrMask[CFG_PULLDIS_BIT]) pullDisQ <= wrVal[CFG_PULLDIS_BIT];
        if (wrMask[CFG_XBAR_BIT])    xbarEnQ  <= wrVal[CFG_XBAR_BIT];
      end
    end
  end

  // Pin synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];

  // Per-pin pad control
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : gPad
      assign outVal[i]    = (xbarEnQ & periphOwn[i]) ? periphOut[i] : portLatch[i];
      assign padOe[i]     = inModeQ[i] & (outModeQ[i] | ~outVal[i]);
      assign padOut[i]    = inModeQ[i] & outModeQ[i] & outVal[i];
      assign padPullUp[i] = inModeQ[i] & ~pullDisQ & ~(padOe[i] & ~padOut[i]);
    end
  endgenerate

  // Read mux
  always_comb begin
    busRdata = '0;
    if (strobes.rdEn) begin
      unique case (strobes.rdSel)
        REG_PORT:  busRdata = strobes.rdRmw ? portLatch : (pinSync & inModeQ);
        REG_OMODE: busRdata = outModeQ;
        REG_IMODE: busRdata = inModeQ;
        REG_CFG: begin
          busRdata[CFG_PULLDIS_BIT] = pullDisQ;
          busRdata[CFG_XBAR_BIT]    = xbarEnQ;
        end
        default:   busRdata = '0;
      endcase
    end
  end

  // Assertions
  a_r2_byte_write: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrPort & ~strobes.bitMode) |=> (portLatch == $past(busWdata)));

  a_r3_bit_write_isolated: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrPort & strobes.bitMode) |=>
      ((portLatch & ~$past(wrMask)) == ($past(portLatch) & ~$past(wrMask))));

  a_r5_analog_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdEn & ~strobes.rdRmw & (strobes.rdSel == REG_PORT)) |->
      ((busRdata & ~inModeQ) == '0));

  a_r6_rmw_reads_latch: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdRmw & (strobes.rdSel == REG_PORT)) |-> (busRdata == portLatch));

  a_r8_od_never_drives_high: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe & padOut & ~outModeQ) == '0));

  a_r9_analog_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (((padOe | padPullUp) & ~inModeQ) == '0));

  a_r10_pull_disabled: assert property (@(posedge clk) disable iff (!rstN)
    pullDisQ |-> (padPullUp == '0));

endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPortPkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic             busRmw,
  input  logic             busBitMode,
  input  logic [IDX_W-1:0] busBitIdx,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] periphOwn,
  input  logic [WIDTH-1:0] periphOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullUp
);

  ctrlStrobes_t strobes;

  gpioPortCtrl uCtrl (
    .busSel     (busSel),
    .busWrite   (busWrite),
    .busRmw     (busRmw),
    .busBitMode (busBitMode),
    .busAddr    (busAddr),
    .strobes    (strobes)
  );

  gpioPortDatapath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busBitIdx (busBitIdx),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .pinIn     (pinIn),
    .periphOwn (periphOwn),
    .periphOut (periphOut),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp)
  );

endmodule

// File: tb/tb_gpioPort.sv
`timescale 1ns/1ps
module tb_gpioPort;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 0, busWrite = 0, busRmw = 0, busBitMode = 0;
  logic [2:0] busBitIdx = '0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic [7:0] pinIn = '0, periphOwn = '0, periphOut = '0;
  logic [7:0] padOe, padOut, padPullUp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpioPort dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busRmw(busRmw),
    .busBitMode(busBitMode), .busBitIdx(busBitIdx), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .periphOwn(periphOwn), .periphOut(periphOut),
    .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busBitMode = 0; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic wrBit(input logic [1:0] a, input logic [2:0] idx, input logic v);
    @(negedge clk);
    busSel = 1; busWrite = 1; busBitMode = 1; busAddr = a; busBitIdx = idx;
    busWdata = {7'h55, v};
    @(negedge clk);
    busSel = 0; busWrite = 0; busBitMode = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic rmw, output logic [7:0] d);
    busSel = 1; busWrite = 0; busRmw = rmw; busAddr = a;
    #1 d = busRdata;
    busSel = 0; busRmw = 0;
  endtask

  task automatic checkPads(input string tag, input logic [7:0] oe, input logic [7:0] o,
                           input logic [7:0] pu);
    check({tag, " padOe"}, padOe, oe);
    check({tag, " padOut"}, padOut, o);
    check({tag, " padPullUp"}, padPullUp, pu);
  endtask

  task automatic testReset();
    logic [7:0] d;
    @(negedge clk);
    rd(2'd3, 0, d); check("R1 cfg", d, 8'h00);
    rd(2'd1, 0, d); check("R1 outMode", d, 8'h00);
    rd(2'd2, 0, d); check("R1 inMode", d, 8'hFF);
    rd(2'd0, 1, d); check("R1 latch", d, 8'hFF);
    checkPads("R1 R8 R10 reset", 8'h00, 8'h00, 8'hFF);
  endtask

  task automatic testByteWrite();
    logic [7:0] d;
    wr(2'd1, 8'hA5); rd(2'd1, 0, d); check("R2 outMode", d, 8'hA5);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h3C); rd(2'd0, 1, d); check("R2 latch", d, 8'h3C);
    wr(2'd3, 8'h03); rd(2'd3, 0, d); check("R2 cfg", d, 8'h03);
    wr(2'd3, 8'h00);
  endtask

  task automatic testBitWrite();
    logic [7:0] d;
    wrBit(2'd0, 3'd0, 1'b1); rd(2'd0, 1, d); check("R3 set bit0", d, 8'h3D);
    wrBit(2'd0, 3'd5, 1'b0); rd(2'd0, 1, d); check("R3 clear bit5", d, 8'h1D);
    wrBit(2'd2, 3'd7, 1'b0); rd(2'd2, 0, d); check("R3 inMode bit7", d, 8'h7F);
    wrBit(2'd2, 3'd7, 1'b1);
    wrBit(2'd3, 3'd1, 1'b1); rd(2'd3, 0, d); check("R3 cfg bit1", d, 8'h02);
    wrBit(2'd3, 3'd1, 1'b0);
  endtask

  task automatic testSync();
    logic [7:0] d;
    @(negedge clk); pinIn = 8'h00;
    repeat (3) @(negedge clk);
    pinIn = 8'h5A;
    @(negedge clk); rd(2'd0, 0, d); check("R4 one edge old", d, 8'h00);
    @(negedge clk); rd(2'd0, 0, d); check("R4 two edges new", d, 8'h5A);
  endtask

  task automatic testRmw();
    logic [7:0] d;
    @(negedge clk); pinIn = 8'hE2;
    repeat (2) @(negedge clk);
    rd(2'd0, 0, d); check("R6 plain read pins", d, 8'hE2);
    rd(2'd0, 1, d); check("R6 rmw read latch", d, 8'h1D);
  endtask

  task automatic testAnalog();
    logic [7:0] d;
    wr(2'd0, 8'h00);
    pinIn = 8'hFF;
    wr(2'd2, 8'h0F);
    @(negedge clk);
    rd(2'd0, 0, d); check("R5 analog reads 0", d, 8'h0F);
    rd(2'd0, 1, d); check("R5 R6 rmw latch", d, 8'h00);
    checkPads("R9 analog", 8'h0F, 8'h00, 8'h00);
    wr(2'd2, 8'hFF);
  endtask

  task automatic testPushPull();
    wr(2'd1, 8'hFF); wr(2'd0, 8'h96);
    checkPads("R7 R10 push-pull", 8'hFF, 8'h96, 8'h96);
  endtask

  task automatic testOpenDrain();
    wr(2'd1, 8'h00);
    checkPads("R8 R10 open-drain", 8'h69, 8'h00, 8'h96);
    wr(2'd3, 8'h01);
    checkPads("R10 pull disabled", 8'h69, 8'h00, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic testCrossbar();
    logic [7:0] d;
    wr(2'd1, 8'hFF); wr(2'd0, 8'h00);
    periphOwn = 8'hF0; periphOut = 8'hA5;
    @(negedge clk);
    check("R11 xbar off latch", padOut, 8'h00);
    wr(2'd3, 8'h02);
    check("R11 xbar on periph", padOut, 8'hA0);
    pinIn = 8'h33;
    repeat (2) @(negedge clk);
    rd(2'd0, 0, d); check("R11 owned pins read", d, 8'h33);
    wr(2'd3, 8'h00);
    check("R11 xbar off again", padOut, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testByteWrite();
    testBitWrite();
    testSync();
    testRmw();
    testAnalog();
    testPushPull();
    testOpenDrain();
    testCrossbar();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule